// File: doc/BRIEF.md
# Printer-Port Host Register Block

This block is the host side of a classic printer port. A processor bus reaches three byte registers at consecutive offsets. Offset 0 holds the outgoing data byte. Offset 1 is a read-only view of the peripheral's status lines. Offset 2 holds the control byte that drives the handshake and mode lines toward the peripheral. The eight data lines and four control outputs come straight from the registers. The five status inputs pass through a two-stage synchronizer before they reach the status view, and the busy line is inverted on the way.

A rising edge on the acknowledge input can raise an interrupt request. A small state machine decides whether it does. It has three states:

- `IRQ_OFF`: the interrupt enable is clear.
- `IRQ_WAIT`: the port is armed and waiting for an edge.
- `IRQ_PEND`: a request is being held.

Its transitions are:

- *arm*: `IRQ_OFF` to `IRQ_WAIT`, when the enable is set.
- *hit*: `IRQ_WAIT` to `IRQ_PEND`, on a synchronized acknowledge rise.
- *ack-read*: `IRQ_PEND` to `IRQ_WAIT`, on a status read with no new rise in the same cycle.
- *hold*: `IRQ_PEND` stays in `IRQ_PEND`, on a fresh rise.
- *disarm*: any state to `IRQ_OFF`, when the enable is clear.

Software polls the status byte or waits for the request, and then reads status to clear it.

Top module: `ppi_host_port`

## Requirements
- R1: After reset, the data register reads 0x00 and the control register reads 0x00. `pd_out` is 0x00 and `irq` is low.
- R2: A write to offset 0 updates `pd_out` on the next clock, and a read of offset 0 returns the same byte. With no write to offset 0, `pd_out` holds its value.
- R3: Control bits 4:0 are stored, and bits 7:5 read back as 0. The pins follow the stored bits as follows: `strobe_n` = NOT bit 0, `autofd_n` = NOT bit 1, `init_n` = bit 2 (so 0 asserts the active-low init line), and `select_out` = bit 3. Writing 0x08 raises `select_out`.
- R4: A status read returns the synchronized pins, valid two clocks after a pin change. Bit 7 is NOT busy, bit 6 is acknowledge, bit 5 is paper-out, bit 4 is select-in and bit 3 is error. Bits 2:0 are always 0.
- R5: Writes to offset 1 and offset 3 change no register or pin, and a read of offset 3 returns 0x00.
- R6: With control bit 4 set, a low-to-high transition of `pin_ack` raises `irq` within three clocks. `irq` then stays high.
- R7: A high-to-low transition of `pin_ack` never raises `irq`.
- R8: A read of offset 1 clears a pending `irq`, and a level that stays high after the read does not raise it again.
- R9: Clearing control bit 4 drops `irq` within two clocks. Acknowledge rises that arrive while bit 4 is clear are lost, so setting the bit again does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of offset 1 clears the request) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pd_out | output | 8 | Data lines |
| strobe_n | output | 1 | Strobe line, active low |
| autofd_n | output | 1 | Auto-feed line, active low |
| init_n | output | 1 | Init line, active low |
| select_out | output | 1 | Select line toward the peripheral |
| pin_busy | input | 1 | Busy line from the peripheral |
| pin_ack | input | 1 | Acknowledge line from the peripheral |
| pin_paper_out | input | 1 | Paper-out line |
| pin_select_in | input | 1 | Select-in line |
| pin_error | input | 1 | Error line |
| irq | output | 1 | Interrupt request, held until cleared |

## Verification
The assertions take for granted the following about the inputs:

- A bus cycle is a single clock with at most one of read or write asserted.
- Peripheral pins may change at any time, since they are synchronized before use.

The stimulus keeps inside these bounds:

- Bus strobes are driven for exactly one clock, away from the active edge.
- After each pin change, the bench waits several clocks before it samples status or the request.

Random register writes and pin patterns are interleaved with directed acknowledge edges in every enable state.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int CTL_W   = 5;
    localparam int STAT_W  = 5;
    localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd2;
    // control bit positions
    localparam int CB_STROBE = 0;
    localparam int CB_AUTOFD = 1;
    localparam int CB_INIT   = 2;
    localparam int CB_SELECT = 3;
    localparam int CB_IRQEN  = 4;
    // synchronized status vector positions
    localparam int SV_ERR  = 0;
    localparam int SV_SLCT = 1;
    localparam int SV_PE   = 2;
    localparam int SV_ACK  = 3;
    localparam int SV_BUSY = 4;

    typedef enum logic [1:0] {
        IRQ_OFF  = 2'd0,
        IRQ_WAIT = 2'd1,
        IRQ_PEND = 2'd2
    } irq_state_e;
endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ppi_regs.sv
module ppi_regs
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [STAT_W-1:0] stat_s,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] data_q,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              stat_rd
);
    localparam int PAD_W = BYTE_W - CTL_W;

    logic [BYTE_W-1:0] stat_view;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ctl_q  <= '0;
        end else if (wr) begin
            if (addr == OFS_DATA) data_q <= wdata;
            if (addr == OFS_CTRL) ctl_q  <= wdata[CTL_W-1:0];
        end
    end

    always_comb begin
        stat_view = {~stat_s[SV_BUSY], stat_s[SV_ACK], stat_s[SV_PE],
                     stat_s[SV_SLCT], stat_s[SV_ERR], 3'b000};
        unique case (addr)
            OFS_DATA: rdata = data_q;
            OFS_STAT: rdata = stat_view;
            OFS_CTRL: rdata = {{PAD_W{1'b0}}, ctl_q};
            default:  rdata = '0;
        endcase
    end

    assign stat_rd = rd && (addr == OFS_STAT);

    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == OFS_DATA) |=> $stable(data_q));
    p_ctl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == OFS_CTRL) |=> $stable(ctl_q));
    p_ctl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_CTRL) |=> ctl_q == $past(wdata[CTL_W-1:0]));
endmodule

// File: rtl/ppi_irq_fsm.sv
module ppi_irq_fsm
    import ppi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rise,
    input  logic stat_rd,
    output logic irq
);
    irq_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IRQ_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = IRQ_OFF;                          // disarm
        end else begin
            unique case (state)
                IRQ_OFF:  nxt = IRQ_WAIT;           // arm
                IRQ_WAIT: if (rise) nxt = IRQ_PEND; // hit
                IRQ_PEND: if (stat_rd && !rise) nxt = IRQ_WAIT; // ack-read
                default:  nxt = IRQ_OFF;
            endcase
        end
    end

    always_comb begin
        irq = (state == IRQ_PEND);
    end

    p_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !irq);
    p_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state != IRQ_OFF && rise) |=> irq);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && stat_rd && !rise) |=> !irq);
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !rise) |=> !irq);
endmodule

// File: rtl/ppi_host_port.sv
module ppi_host_port
    import ppi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic [7:0] pd_out,
    output logic       strobe_n,
    output logic       autofd_n,
    output logic       init_n,
    output logic       select_out,
    input  logic       pin_busy,
    input  logic       pin_ack,
    input  logic       pin_paper_out,
    input  logic       pin_select_in,
    input  logic       pin_error,
    output logic       irq
);
    logic [STAT_W-1:0] pins_raw, pins_s;
    logic [CTL_W-1:0]  ctl_q;
    logic              stat_rd;
    logic              ack_prev;
    logic              ack_rise;

    assign pins_raw = {pin_busy, pin_ack, pin_paper_out, pin_select_in, pin_error};

    ppi_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst_n (rst_n), .d (pins_raw), .q (pins_s)
    );

    ppi_regs u_regs (
        .clk (clk), .rst_n (rst_n), .addr (bus_addr), .wr (bus_wr),
        .rd (bus_rd), .wdata (bus_wdata), .stat_s (pins_s),
        .rdata (bus_rdata), .data_q (pd_out), .ctl_q (ctl_q),
        .stat_rd (stat_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_prev <= 1'b0;
        else        ack_prev <= pins_s[SV_ACK];
    end
    assign ack_rise = pins_s[SV_ACK] & ~ack_prev;

    ppi_irq_fsm u_fsm (
        .clk (clk), .rst_n (rst_n), .enable (ctl_q[CB_IRQEN]),
        .rise (ack_rise), .stat_rd (stat_rd), .irq (irq)
    );

    assign strobe_n   = ~ctl_q[CB_STROBE];
    assign autofd_n   = ~ctl_q[CB_AUTOFD];
    assign init_n     =  ctl_q[CB_INIT];
    assign select_out =  ctl_q[CB_SELECT];

    p_falling_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !pins_s[SV_ACK]) |=> !irq);
    p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rise |=> !ack_rise);
endmodule

// File: tb/ppi_host_port_bench.sv
module ppi_host_port_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata, pd_out;
    logic strobe_n, autofd_n, init_n, select_out, irq;
    logic pin_busy = 0, pin_ack = 0, pin_paper_out = 0, pin_select_in = 0, pin_error = 0;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] m_data = 8'h00, m_ctl = 8'h00;
    logic m_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppi_host_port u_ppi_host_port (.*);

    function automatic logic [7:0] f_status(input logic b, a, p, s, e);
        return {~b, a, p, s, e, 3'b000};
    endfunction
    function automatic logic [3:0] f_pins(input logic [7:0] c);
        return {~c[0], ~c[1], c[2], c[3]};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_cy(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctl(input logic [7:0] v);
        bus_write(2'd2, v);
        m_ctl = {3'b000, v[4:0]};
        if (!v[4]) m_pend = 1'b0;
        wait_cy(3);
    endtask

    task automatic drive_ack(input logic v);
        @(negedge clk);
        if (v && !pin_ack && m_ctl[4]) m_pend = 1'b1;
        pin_ack = v;
        wait_cy(5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'd4711));
        wait_cy(3);
        #1 check("R1 irq at reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        wait_cy(3);
        check("R1 pd_out", pd_out, 8'h00);
        bus_read(2'd0, rd); check("R1 data", rd, 8'h00);
        bus_read(2'd2, rd); check("R1 ctl", rd, 8'h00);
        check("R3 pins reset", {4'd0, f_pins(8'h00)}, {4'd0, strobe_n, autofd_n, init_n, select_out});

        // directed control cases
        set_ctl(8'h08);
        check("R3 select raised", {7'd0, select_out}, 8'h01);
        set_ctl(8'hFF);
        bus_read(2'd2, rd); check("R3 upper bits zero", rd, 8'h1F);
        set_ctl(8'h00);

        // R5: ignored offsets
        bus_write(2'd0, 8'h5A); m_data = 8'h5A;
        bus_write(2'd1, 8'hC3);
        bus_write(2'd3, 8'h3C);
        wait_cy(1);
        check("R5 data unchanged", pd_out, 8'h5A);
        bus_read(2'd2, rd); check("R5 ctl unchanged", rd, 8'h00);
        bus_read(2'd3, rd); check("R5 offset3 reads zero", rd, 8'h00);

        // R6/R8: edge, hold, clear, no re-raise on level
        set_ctl(8'h10);
        drive_ack(1'b1);
        check("R6 irq after rise", {7'd0, irq}, 8'h01);
        wait_cy(4);
        check("R6 irq holds", {7'd0, irq}, 8'h01);
        bus_read(2'd1, rd); m_pend = 1'b0;
        check("R8 irq cleared", {7'd0, irq}, 8'h00);
        wait_cy(5);
        check("R8 level no re-raise", {7'd0, irq}, 8'h00);
        // R7: falling edge
        drive_ack(1'b0);
        check("R7 falling quiet", {7'd0, irq}, 8'h00);
        // R9: disable drops, edges lost
        drive_ack(1'b1);
        check("R6 second rise", {7'd0, irq}, 8'h01);
        bus_write(2'd2, 8'h00); m_ctl = 8'h00; m_pend = 1'b0;
        wait_cy(2);
        check("R9 disable drops irq", {7'd0, irq}, 8'h00);
        drive_ack(1'b0);
        drive_ack(1'b1);
        set_ctl(8'h10);
        wait_cy(3);
        check("R9 lost edge", {7'd0, irq}, 8'h00);
        drive_ack(1'b0);

        // random phase
        for (int i = 0; i < 60; i++) begin
            logic [7:0] d, c;
            d = 8'($urandom); c = 8'($urandom);
            bus_write(2'd0, d); m_data = d;
            set_ctl(c);
            check("R2 pd_out", pd_out, m_data);
            bus_read(2'd0, rd); check("R2 data readback", rd, m_data);
            bus_read(2'd2, rd); check("R3 ctl readback", rd, m_ctl);
            check("R3 ctl pins", {4'd0, strobe_n, autofd_n, init_n, select_out}, {4'd0, f_pins(m_ctl)});
            @(negedge clk);
            pin_busy = 1'($urandom); pin_paper_out = 1'($urandom);
            pin_select_in = 1'($urandom); pin_error = 1'($urandom);
            drive_ack(1'($urandom));
            check("R6 irq model", {7'd0, irq}, {7'd0, m_pend});
            bus_read(2'd1, rd); m_pend = 1'b0;
            check("R4 status", rd, f_status(pin_busy, pin_ack, pin_paper_out, pin_select_in, pin_error));
            check("R8 irq after read", {7'd0, irq}, 8'h00);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule